// File: doc/BRIEF.md
# Program-Flow Discontinuity Tracer

This block watches the instruction fetch stream of a processor core and reports only the places where program flow jumps. A fetch counts as a jump when its address differs from the address of the previous valid fetch plus the instruction size. Branches, loop back-edges, calls and interrupt entries all produce such jumps. The target address of each jump is stored in a small on-chip queue. Sequential fetches produce no record at all.

The queue is emptied one entry at a time onto a trace port, and only in cycles that the core's external bus leaves idle. Trace output therefore never competes with normal bus traffic. When jumps arrive faster than idle slots can drain them, for example in a tight loop, new targets are dropped while the queue is full. A sticky overflow bit is then raised, and the first target accepted after a loss carries a gap mark. Off-chip software can use that mark to tell where its reconstruction of program flow is no longer complete.

A two-state detector (`DET_COLD`: no previous fetch known; `DET_WARM`: previous address held) decides which fetches are jumps. Transitions are as follows. `COLD_TO_WARM` happens on a valid fetch while tracing is enabled. `WARM_TO_COLD` happens whenever tracing is disabled. `COLD_HOLD` covers every other cycle in `DET_COLD`. `WARM_HOLD` covers every cycle in `DET_WARM` while tracing stays enabled.

Top module: `ns_fetch_tracer`

## Requirements
- R1: While reset is held, and right after it is released, `trace_valid` and `overflow` are 0.
- R2: The first valid fetch after reset, or after `trace_en` goes high again, is always recorded, even if its address looks sequential.
- R3: A valid fetch whose address equals the previous valid fetch address plus 4, computed modulo 2^32 (so 0xFFFFFFFC followed by 0x00000000 is sequential), is not recorded.
- R4: Every other valid fetch while enabled is recorded, and recorded targets appear on `trace_addr` in fetch order.
- R5: An entry is emitted, with `trace_valid` high for one cycle, only in the cycle after a clock edge at which `bus_idle` was high and the queue held at least one entry. At most one entry is emitted per such edge.
- R6: The queue holds 8 entries. A target that arrives at an edge when 8 entries are held is dropped, even if an entry leaves at that same edge.
- R7: `overflow` goes high after the edge at which a target is dropped and stays high until reset.
- R8: `trace_gap` is 1 on the emitted entry that was the first one accepted after one or more drops, and 0 on every other entry.
- R9: While `trace_en` is low, no fetch is recorded. Entries already queued still drain.
- R10: When `fetch_valid` is low, `fetch_addr` is ignored and the remembered previous address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing enable |
| fetch_valid | input | 1 | A fetch occurs this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| bus_idle | input | 1 | External bus free this cycle |
| trace_valid | output | 1 | Trace entry present on `trace_addr` |
| trace_addr | output | 32 | Emitted jump target |
| trace_gap | output | 1 | Targets were lost just before this entry |
| overflow | output | 1 | Sticky: at least one target was dropped |

## Verification
A fetch sampled at edge t is in the queue after edge t. If `bus_idle` is high at edge t+1 and the entry is at the head, it appears on `trace_valid`/`trace_addr` just after edge t+1. `overflow` is high just after the edge that drops a target. The bench drives inputs on the falling edge and keeps a cycle-accurate model of the queue. It advances the model at each rising edge and compares all four outputs one nanosecond after that edge, so each result is checked in exactly the cycle it is due. Directed sections also count the emitted entries against hand-derived totals.

// File: rtl/ns_trace_pkg.sv
package ns_trace_pkg;
    localparam int NS_ADDR_W = 32;

    typedef struct packed {
        logic                 gap;
        logic [NS_ADDR_W-1:0] addr;
    } trace_entry_t;

    typedef enum logic [0:0] {
        DET_COLD = 1'b0,
        DET_WARM = 1'b1
    } det_state_e;
endpackage

// File: rtl/ns_disc_detect.sv
module ns_disc_detect
    import ns_trace_pkg::*;
#(
    parameter int STEP_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 fetch_valid,
    input  logic [NS_ADDR_W-1:0] fetch_addr,
    output logic                 target_hit
);
    localparam logic [NS_ADDR_W-1:0] STEP = NS_ADDR_W'(STEP_BYTES);

    det_state_e           state, state_nxt;
    logic [NS_ADDR_W-1:0] last_addr;
    logic                 take;

    assign take = enable && fetch_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= DET_COLD;
        else        state <= state_nxt;
    end

    // remembered address of the last valid fetch
    always_ff @(posedge clk) begin
        if (!rst_n)    last_addr <= '0;
        else if (take) last_addr <= fetch_addr;
    end

    // transitions and output
    always_comb begin
        state_nxt  = state;
        target_hit = 1'b0;
        unique case (state)
            DET_COLD: begin
                target_hit = take;
                if (take) state_nxt = DET_WARM;   // COLD_TO_WARM
            end
            DET_WARM: begin
                target_hit = take && (fetch_addr != last_addr + STEP);
                if (!enable) state_nxt = DET_COLD; // WARM_TO_COLD
            end
            default: state_nxt = DET_COLD;
        endcase
    end
endmodule

// File: rtl/ns_trace_fifo.sv
module ns_trace_fifo
    import ns_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  trace_entry_t     din,
    input  logic             pop,
    output trace_entry_t     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] fill
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    trace_entry_t     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (fill == CAP);
    assign empty = (fill == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ns_fetch_tracer.sv
module ns_fetch_tracer
    import ns_trace_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int STEP_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trace_en,
    input  logic                 fetch_valid,
    input  logic [NS_ADDR_W-1:0] fetch_addr,
    input  logic                 bus_idle,
    output logic                 trace_valid,
    output logic [NS_ADDR_W-1:0] trace_addr,
    output logic                 trace_gap,
    output logic                 overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             hit, full, empty, accept, drop, pop, gap_pend;
    logic [CNT_W-1:0] fill;
    trace_entry_t     head, wr_entry;

    ns_disc_detect #(.STEP_BYTES(STEP_BYTES)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (trace_en),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .target_hit  (hit)
    );

    // full is judged on occupancy before this edge's pop
    assign accept = hit && !full;
    assign drop   = hit && full;
    assign pop    = bus_idle && !empty;

    assign wr_entry.gap  = gap_pend;
    assign wr_entry.addr = fetch_addr;

    ns_trace_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (wr_entry),
        .pop   (pop),
        .dout  (head),
        .full  (full),
        .empty (empty),
        .fill  (fill)
    );

    // loss bookkeeping: sticky flag and mark for next accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_pend <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (drop) begin
                gap_pend <= 1'b1;
                overflow <= 1'b1;
            end else if (accept) begin
                gap_pend <= 1'b0;
            end
        end
    end

    // trace port register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_valid <= 1'b0;
            trace_addr  <= '0;
            trace_gap   <= 1'b0;
        end else begin
            trace_valid <= pop;
            if (pop) begin
                trace_addr <= head.addr;
                trace_gap  <= head.gap;
            end else begin
                trace_gap  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ns_fetch_tracer_chk.sv
module ns_fetch_tracer_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trace_en,
    input logic             bus_idle,
    input logic             trace_valid,
    input logic             trace_gap,
    input logic             overflow,
    input logic [CNT_W-1:0] fill
);
    p_emit_on_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_valid |-> ($past(bus_idle) && ($past(fill) != '0)));

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_gap_implies_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_valid && trace_gap) |-> overflow);

    p_no_record_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> (fill <= $past(fill)));

    p_one_per_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_valid |-> (($past(fill) - fill) <= CNT_W'(1)));
endmodule

bind ns_fetch_tracer ns_fetch_tracer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trace_en    (trace_en),
    .bus_idle    (bus_idle),
    .trace_valid (trace_valid),
    .trace_gap   (trace_gap),
    .overflow    (overflow),
    .fill        (fill)
);

// File: tb/ns_fetch_tracer_bench.sv
`timescale 1ns/1ps
module ns_fetch_tracer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bus_idle = 1'b0;
    logic        trace_valid, trace_gap, overflow;
    logic [31:0] trace_addr;

    always #4 clk = ~clk;   // 125 MHz

    ns_fetch_tracer u_ns_fetch_tracer (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .bus_idle(bus_idle), .trace_valid(trace_valid),
        .trace_addr(trace_addr), .trace_gap(trace_gap),
        .overflow(overflow)
    );

    int compared = 0, mismatched = 0, emitted = 0;
    bit done = 1'b0;

    // reference model state
    logic [32:0] mq[$];
    logic [31:0] m_prev;
    bit          m_warm, m_pend, m_ovf;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mq.delete(); m_prev = '0; m_warm = 0; m_pend = 0; m_ovf = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trace_en = 1'b0; fetch_valid = 1'b0; bus_idle = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "valid in reset", 32'(trace_valid), 0);
        check("R1", "overflow in reset", 32'(overflow), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic step(input bit en, input bit fv, input logic [31:0] a, input bit idle);
        bit          ev, eg, hit;
        logic [31:0] ea;
        int          sz;
        @(negedge clk);
        trace_en = en; fetch_valid = fv; fetch_addr = a; bus_idle = idle;
        @(posedge clk);
        ev = 0; eg = 0; ea = '0;
        sz = mq.size();
        hit = en && fv && (!m_warm || a != m_prev + 32'd4);
        if (idle && sz > 0) begin
            ev = 1; {eg, ea} = mq.pop_front();
        end
        if (hit) begin
            if (sz == 8) begin m_ovf = 1; m_pend = 1; end
            else begin mq.push_back({m_pend, a}); m_pend = 0; end
        end
        if (!en) m_warm = 0;
        else if (fv) begin m_warm = 1; m_prev = a; end
        #1;
        check("R5", "trace_valid", 32'(trace_valid), 32'(ev));
        if (ev) begin
            check("R4", "trace_addr", trace_addr, ea);
            check("R8", "trace_gap", 32'(trace_gap), 32'(eg));
        end
        check("R7", "overflow", 32'(overflow), 32'(m_ovf));
        if (trace_valid) emitted++;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 32'hDEAD_0000, 1'b1);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        check("R1", "valid after release", 32'(trace_valid), 0);
        check("R1", "overflow after release", 32'(overflow), 0);

        // R2: first fetch recorded though sequential-looking ones follow
        emitted = 0;
        step(1, 1, 32'h200, 0); step(1, 1, 32'h204, 0); step(1, 1, 32'h208, 0);
        drain(4);
        check("R2", "entries after first fetch", emitted, 1);

        // R3: modulo wrap is sequential, jump afterwards is recorded
        emitted = 0;
        step(1, 1, 32'hFFFF_FFF8, 0); step(1, 1, 32'hFFFF_FFFC, 0);
        step(1, 1, 32'h0, 0); step(1, 1, 32'h4, 0); step(1, 1, 32'h40, 0);
        drain(4);
        check("R3", "entries across wrap", emitted, 2);

        // R10: address with fetch_valid low is ignored
        emitted = 0;
        step(1, 1, 32'h300, 0); step(1, 0, 32'h999, 0); step(1, 0, 32'h0, 1);
        step(1, 1, 32'h304, 0);
        drain(4);
        check("R10", "entries with invalid gaps", emitted, 1);

        // R9: disabled fetches ignored, first after re-enable recorded
        emitted = 0;
        step(1, 1, 32'h700, 0);
        step(0, 1, 32'h500, 1); step(0, 1, 32'h600, 1);
        step(1, 1, 32'h604, 0); step(1, 1, 32'h608, 0);
        drain(4);
        check("R9", "entries around disable", emitted, 2);

        // R6: 12 jumps without idle slots, only 8 kept
        do_reset();
        emitted = 0;
        for (int i = 0; i < 12; i++) step(1, 1, 32'h1000 + 32'(i) * 16, 0);
        check("R6", "overflow after excess", 32'(overflow), 1);
        step(1, 1, 32'h9000, 1);   // pop and push at same edge while full: dropped
        drain(10);
        check("R6", "entries kept", emitted, 8);
        step(1, 1, 32'hA000, 0);   // first accepted after loss carries the gap
        drain(3);
        check("R7", "overflow still set", 32'(overflow), 1);

        // sweep: loop bodies of 1..6 fetches against idle every 1..4 cycles
        for (int body = 1; body <= 6; body++) begin
            for (int k = 1; k <= 4; k++) begin
                int pos;
                do_reset();
                pos = 0;
                for (int c = 0; c < 40; c++) begin
                    bit fv;
                    fv = (c % 5) != 4;
                    step(1, fv, fv ? 32'h10_0000 * body + 32'(pos) * 4 : 32'h1234_5678,
                         (c % k) == 0);
                    if (fv) pos = (pos + 1) % body;
                end
                drain(12);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule